// File: doc/BRIEF.md
# Contactless Tag Poll and Read Responder

This block plays the card side of a 212 kbit/s contactless link. A receiver in front of it assembles reader frames into a byte buffer. When a frame is complete, the receiver raises a done flag and a CRC-ok flag. The responder reads the length, command and request-code bytes out of that buffer and decides whether to answer. If it answers, it builds one of three fixed response images with the current 8-byte card identifier inserted and a CRC-16 appended. It then offers that image to a transmitter, which fetches bytes by index and signals when it has finished.

Whether or not a reply is sent, the responder ends each frame by pulsing a clear to the receiver and then returns to listening. It also keeps a direction flag, taken from the parity of the last accepted command code: reader commands are even and card answers are odd.

The state machine has eight states. ST_LISTEN waits for a done frame. It goes to ST_GET_LEN when the CRC is good, or straight to ST_FLUSH when it is bad. ST_GET_LEN, ST_GET_CMD and ST_GET_REQ each fetch one byte, in that order. ST_CHOOSE picks a template, or goes to ST_FLUSH when no rule matches. ST_BUILD runs the CRC over the image one byte per cycle. ST_OFFER holds the request until the transmitter is done, then goes to ST_FLUSH. ST_FLUSH pulses the receiver clear and goes back to ST_LISTEN.

Top module: `tag_responder`

## Requirements
- R1: After reset, rsp_req, rx_clear and dir_reader are all 0.
- R2: A good frame with byte 2 = 6, byte 3 = 0x00 and byte 6 = 0 is answered with a 22-byte image. The image is B2 4D, length 0x12, code 0x01, the identifier (id_in[63:56] first) at indices 4..11, then 00 F1 00 00 00 01 43 00, then the CRC.
- R3: The same frame with byte 6 = 1 is answered with a 24-byte image. It has length 0x14 and code 0x01, the identifier at 4..11, the same 8 payload bytes, then 88 B4 at indices 20..21, then the CRC.
- R4: A good frame with byte 3 = 0x06 and byte 2 greater than 5 is answered with a 33-byte image. It has length 0x1D and code 0x07, the identifier at 4..11, then 00 00 01 10 04 01 00 0D 00 00 00 00 00 01 00 00 00 00 23, then the CRC.
- R5: The CRC is CRC-16, polynomial 0x1021, initial value 0, MSB first. It covers image indices 2 through L+1, where L is the length byte. It is placed high byte at index L+2 and low byte at L+3.
- R6: A frame flagged with a bad CRC produces no request; rx_clear pulses instead.
- R7: A good frame that matches none of the rules in R2 to R4 produces no request; rx_clear pulses instead. This covers a poll with byte 6 above 1, a poll whose length is not 6, a read with length 5 or less, and any other command.
- R8: After each good frame, dir_reader equals the inverse of bit 0 of its byte 3.
- R9: While replying, rsp_req stays high until tx_done. On the next cycle rsp_req is 0 and rx_clear is 1 for exactly one cycle.
- R10: An identifier loaded while a reply is offered does not alter that reply's bytes or CRC; the next reply carries it.
- R11: While rsp_req is high, rsp_len is 22, 24 or 33 and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frm_done | input | 1 | Receiver holds a complete frame |
| frm_crc_ok | input | 1 | CRC of that frame checked good |
| rx_idx | output | RX_IDX_W | Index into the receiver buffer |
| rx_byte | input | 8 | Buffer byte at rx_idx, same cycle |
| rx_clear | output | 1 | One-cycle clear to the receiver |
| id_load | input | 1 | Load a new card identifier |
| id_in | input | 8*ID_BYTES | Identifier, first byte in the top bits |
| rsp_req | output | 1 | Response image ready for sending |
| rsp_len | output | IDX_W | Total bytes in the image |
| tx_idx | input | IDX_W | Byte index requested by the transmitter |
| tx_byte | output | 8 | Image byte at tx_idx |
| tx_done | input | 1 | Transmitter finished the image |
| dir_reader | output | 1 | Last accepted frame came from a reader |

## Verification
The bench sweeps command codes 0..15 against lengths on both sides of the 5/6 boundaries and request codes 0..2, with several identifiers. Every valid frame must land on exactly one template or be dropped. A decoder that tests length too loosely would answer a 7-byte poll, and one that ignores the request code would answer type 2 polls. Each image is compared byte by byte, including a CRC computed in the bench, so an off-by-one in the CRC range or swapped CRC bytes shows up at the tail. An identifier swap in the middle of a reply catches a design that reads the live identifier instead of a snapshot. Bad-CRC frames that would otherwise match must produce only a clear pulse.

// File: rtl/tr_pkg.sv
package tr_pkg;
    typedef enum logic [2:0] {
        ST_LISTEN, ST_GET_LEN, ST_GET_CMD, ST_GET_REQ,
        ST_CHOOSE, ST_BUILD, ST_OFFER, ST_FLUSH
    } tr_state_e;

    typedef enum logic [1:0] {RK_NONE, RK_POLL0, RK_POLL1, RK_READ} rsp_kind_e;

    localparam logic [7:0] CMD_POLL = 8'h00;
    localparam logic [7:0] CMD_READ = 8'h06;

    function automatic logic [7:0] len_field(rsp_kind_e k);
        case (k)
            RK_POLL0: return 8'h12;
            RK_POLL1: return 8'h14;
            RK_READ:  return 8'h1D;
            default:  return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/tr_crc_step.sv
module tr_crc_step #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] c;
        c = crc_in ^ {data_in, 8'h00};
        for (int b = 0; b < 8; b++) begin
            c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
        end
        crc_out = c;
    end
endmodule

// File: rtl/tr_template.sv
module tr_template
    import tr_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter int ID_BYTES = 8
) (
    input  rsp_kind_e               kind,
    input  logic [IDX_W-1:0]        idx,
    input  logic [8*ID_BYTES-1:0]   id,
    input  logic [15:0]             crc,
    output logic [7:0]              data
);
    localparam int PAY0 = 4 + ID_BYTES;
    localparam logic [63:0]  POLL_PAY = 64'h00F1_0000_0001_4300;
    localparam logic [151:0] READ_PAY =
        152'h00_0001_1004_0100_0D00_0000_0000_0100_0000_0023;

    always_comb begin
        int i;
        int lf;
        int p;
        i    = int'(idx);
        lf   = int'(len_field(kind));
        p    = i - PAY0;
        data = 8'h00;
        if (i == 0)                 data = 8'hB2;
        else if (i == 1)            data = 8'h4D;
        else if (i == 2)            data = len_field(kind);
        else if (i == 3)            data = (kind == RK_READ) ? 8'h07 : 8'h01;
        else if (i < PAY0)          data = 8'(id >> (8 * (ID_BYTES - 1 - (i - 4))));
        else if (i == lf + 2)       data = crc[15:8];
        else if (i == lf + 3)       data = crc[7:0];
        else if (i < lf + 2) begin
            if (kind == RK_READ)    data = 8'(READ_PAY >> (8 * (18 - p)));
            else if (p < 8)         data = 8'(POLL_PAY >> (8 * (7 - p)));
            else if (p == 8)        data = 8'h88;
            else                    data = 8'hB4;
        end
    end
endmodule

// File: rtl/tag_responder.sv
module tag_responder
    import tr_pkg::*;
#(
    parameter int          RX_IDX_W = 8,
    parameter int          IDX_W    = 6,
    parameter int          ID_BYTES = 8,
    parameter logic [15:0] CRC_POLY = 16'h1021
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_done,
    input  logic                    frm_crc_ok,
    output logic [RX_IDX_W-1:0]     rx_idx,
    input  logic [7:0]              rx_byte,
    output logic                    rx_clear,
    input  logic                    id_load,
    input  logic [8*ID_BYTES-1:0]   id_in,
    output logic                    rsp_req,
    output logic [IDX_W-1:0]        rsp_len,
    input  logic [IDX_W-1:0]        tx_idx,
    output logic [7:0]              tx_byte,
    input  logic                    tx_done,
    output logic                    dir_reader
);
    localparam int IDW = 8 * ID_BYTES;

    tr_state_e            state_q, state_d;
    rsp_kind_e            kind_q, kind_sel;
    logic [7:0]           len_q, cmd_q, req_q;
    logic [IDX_W-1:0]     bld_idx_q, last_idx;
    logic [15:0]          crc_q, crc_nxt;
    logic [IDW-1:0]       id_live, id_snap;
    logic [7:0]           bld_byte;
    logic                 dir_q;

    always_comb begin
        kind_sel = RK_NONE;
        if (cmd_q == CMD_POLL && len_q == 8'd6) begin
            if (req_q == 8'd0)      kind_sel = RK_POLL0;
            else if (req_q == 8'd1) kind_sel = RK_POLL1;
        end else if (cmd_q == CMD_READ && len_q > 8'd5) begin
            kind_sel = RK_READ;
        end
    end

    assign last_idx = IDX_W'(len_field(kind_q)) + IDX_W'(1);
    assign rsp_len  = IDX_W'(len_field(kind_q) + 8'd4);

    tr_template #(.IDX_W(IDX_W), .ID_BYTES(ID_BYTES)) u_bld_tpl (
        .kind(kind_q), .idx(bld_idx_q), .id(id_snap), .crc(crc_q), .data(bld_byte)
    );

    tr_template #(.IDX_W(IDX_W), .ID_BYTES(ID_BYTES)) u_tx_tpl (
        .kind(kind_q), .idx(tx_idx), .id(id_snap), .crc(crc_q), .data(tx_byte)
    );

    tr_crc_step #(.POLY(CRC_POLY)) u_crc (
        .crc_in(crc_q), .data_in(bld_byte), .crc_out(crc_nxt)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LISTEN:  if (frm_done) state_d = frm_crc_ok ? ST_GET_LEN : ST_FLUSH;
            ST_GET_LEN: state_d = ST_GET_CMD;
            ST_GET_CMD: state_d = ST_GET_REQ;
            ST_GET_REQ: state_d = ST_CHOOSE;
            ST_CHOOSE:  state_d = (kind_sel == RK_NONE) ? ST_FLUSH : ST_BUILD;
            ST_BUILD:   if (bld_idx_q == last_idx) state_d = ST_OFFER;
            ST_OFFER:   if (tx_done) state_d = ST_FLUSH;
            ST_FLUSH:   state_d = ST_LISTEN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LISTEN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rx_idx   = '0;
        rx_clear = 1'b0;
        rsp_req  = 1'b0;
        unique case (state_q)
            ST_GET_LEN: rx_idx = RX_IDX_W'(2);
            ST_GET_CMD: rx_idx = RX_IDX_W'(3);
            ST_GET_REQ: rx_idx = RX_IDX_W'(6);
            ST_OFFER:   rsp_req = 1'b1;
            ST_FLUSH:   rx_clear = 1'b1;
            default:    ;
        endcase
    end
    assign dir_reader = dir_q;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= '0;
            cmd_q     <= '0;
            req_q     <= '0;
            kind_q    <= RK_NONE;
            bld_idx_q <= '0;
            crc_q     <= '0;
            id_live   <= '0;
            id_snap   <= '0;
            dir_q     <= 1'b0;
        end else begin
            if (id_load) id_live <= id_in;
            unique case (state_q)
                ST_GET_LEN: len_q <= rx_byte;
                ST_GET_CMD: begin
                    cmd_q <= rx_byte;
                    dir_q <= ~rx_byte[0];
                end
                ST_GET_REQ: req_q <= rx_byte;
                ST_CHOOSE: begin
                    kind_q    <= kind_sel;
                    id_snap   <= id_live;
                    bld_idx_q <= IDX_W'(2);
                    crc_q     <= '0;
                end
                ST_BUILD: begin
                    crc_q     <= crc_nxt;
                    bld_idx_q <= bld_idx_q + IDX_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tag_responder_chk.sv
module tag_responder_chk
    import tr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_done,
    input logic             frm_crc_ok,
    input logic             rx_clear,
    input logic             rsp_req,
    input logic [IDX_W-1:0] rsp_len,
    input logic             tx_done,
    input tr_state_e        state
);
    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_req && rx_clear));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clear |=> !rx_clear);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_req && tx_done) |=> (!rsp_req && rx_clear));

    assert_len_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_req && !tx_done) |=> $stable(rsp_len));

    assert_len_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_req |-> (rsp_len == IDX_W'(22) || rsp_len == IDX_W'(24) || rsp_len == IDX_W'(33)));

    assert_bad_crc_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LISTEN && frm_done && !frm_crc_ok) |=> (rx_clear && !rsp_req));
endmodule

bind tag_responder tag_responder_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_crc_ok(frm_crc_ok),
    .rx_clear(rx_clear), .rsp_req(rsp_req), .rsp_len(rsp_len),
    .tx_done(tx_done), .state(state_q)
);

// File: tb/tag_responder_test.sv
module tag_responder_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        frm_done = 0, frm_crc_ok = 0;
    logic [7:0]  rx_idx;
    logic [7:0]  rx_byte;
    logic        rx_clear;
    logic        id_load = 0;
    logic [63:0] id_in = '0;
    logic        rsp_req;
    logic [5:0]  rsp_len;
    logic [5:0]  tx_idx = '0;
    logic [7:0]  tx_byte;
    logic        tx_done = 0;
    logic        dir_reader;

    logic [7:0]  rxb [0:255];
    int n_run = 0, n_fail = 0;
    logic [63:0] cur_id;

    always #10 clk = ~clk;
    assign rx_byte = rxb[rx_idx];

    tag_responder uut (
        .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm_crc_ok(frm_crc_ok),
        .rx_idx(rx_idx), .rx_byte(rx_byte), .rx_clear(rx_clear),
        .id_load(id_load), .id_in(id_in), .rsp_req(rsp_req), .rsp_len(rsp_len),
        .tx_idx(tx_idx), .tx_byte(tx_byte), .tx_done(tx_done), .dir_reader(dir_reader)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected image byte (kind 1 poll0, 2 poll1, 3 read), before CRC
    function automatic logic [7:0] img_byte(int k, int i, logic [63:0] id);
        logic [7:0] pp [0:9];
        logic [7:0] rp [0:18];
        pp = '{8'h00, 8'hF1, 8'h00, 8'h00, 8'h00, 8'h01, 8'h43, 8'h00, 8'h88, 8'hB4};
        rp = '{8'h00, 8'h00, 8'h01, 8'h10, 8'h04, 8'h01, 8'h00, 8'h0D, 8'h00, 8'h00,
               8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h23};
        if (i == 0) return 8'hB2;
        if (i == 1) return 8'h4D;
        if (i == 2) return (k == 1) ? 8'h12 : (k == 2) ? 8'h14 : 8'h1D;
        if (i == 3) return (k == 3) ? 8'h07 : 8'h01;
        if (i < 12) return id[63 - 8*(i-4) -: 8];
        return (k == 3) ? rp[i-12] : pp[i-12];
    endfunction

    task automatic run_frame(input int ln, input int cm, input int rq, input bit ok,
                             input bit mid_load, input logic [63:0] new_id);
        int ek;
        int total;
        bit got_req;
        bit got_clr;
        string tag;
        logic [7:0] exp_b [0:40];
        logic [15:0] c;
        ek = 0;
        if (ok && cm == 0 && ln == 6 && rq == 0) ek = 1;
        else if (ok && cm == 0 && ln == 6 && rq == 1) ek = 2;
        else if (ok && cm == 6 && ln > 5) ek = 3;
        tag = (ek == 1) ? "R2" : (ek == 2) ? "R3" : (ek == 3) ? "R4" : (ok ? "R7" : "R6");
        for (int i = 0; i < 256; i++) rxb[i] = 8'h00;
        rxb[0] = 8'hB2; rxb[1] = 8'h4D;
        rxb[2] = 8'(ln); rxb[3] = 8'(cm); rxb[6] = 8'(rq);
        @(negedge clk);
        frm_done = 1; frm_crc_ok = ok;
        got_req = 0; got_clr = 0;
        for (int cyc = 0; cyc < 80; cyc++) begin
            @(negedge clk);
            if (rsp_req) begin got_req = 1; break; end
            if (rx_clear) begin got_clr = 1; break; end
        end
        if (ok) chk(dir_reader == ~cm[0], "R8", dir_reader, ~cm[0]);
        if (ek == 0) begin
            chk(!got_req && got_clr, tag, got_req, 0);
            frm_done = 0;
            @(negedge clk);
            return;
        end
        chk(got_req, tag, got_req, 1);
        if (!got_req) begin frm_done = 0; return; end
        total = (ek == 1) ? 22 : (ek == 2) ? 24 : 33;
        chk(int'(rsp_len) == total, "R11", rsp_len, total);
        c = 16'h0000;
        for (int i = 0; i < total - 2; i++) begin
            exp_b[i] = img_byte(ek, i, cur_id);
            if (i >= 2) begin
                c = c ^ {exp_b[i], 8'h00};
                for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
            end
        end
        exp_b[total-2] = c[15:8];
        exp_b[total-1] = c[7:0];
        if (mid_load) begin
            id_load = 1; id_in = new_id;
            @(negedge clk);
            id_load = 0;
        end
        begin
            int bad;
            logic [7:0] ab;
            logic [7:0] eb;
            bad = -1; ab = 0; eb = 0;
            for (int i = 0; i < total - 2; i++) begin
                tx_idx = 6'(i); #1;
                if (tx_byte !== exp_b[i] && bad < 0) begin bad = i; ab = tx_byte; eb = exp_b[i]; end
            end
            chk(bad < 0, mid_load ? "R10" : tag, ab, eb);
            bad = -1;
            for (int i = total - 2; i < total; i++) begin
                tx_idx = 6'(i); #1;
                if (tx_byte !== exp_b[i] && bad < 0) begin bad = i; ab = tx_byte; eb = exp_b[i]; end
            end
            chk(bad < 0, mid_load ? "R10" : "R5", ab, eb);
        end
        chk(rsp_req == 1'b1, "R9", rsp_req, 1);
        @(negedge clk);
        tx_done = 1;
        @(negedge clk);
        tx_done = 0;
        chk(!rsp_req && rx_clear, "R9", {rsp_req, rx_clear}, 1);
        frm_done = 0;
        @(negedge clk);
        chk(!rx_clear, "R9", rx_clear, 0);
        if (mid_load) cur_id = new_id;
    endtask

    task automatic load_id(input logic [63:0] v);
        @(negedge clk);
        id_load = 1; id_in = v;
        @(negedge clk);
        id_load = 0;
        cur_id = v;
    endtask

    initial begin
        int lens [0:3];
        logic [63:0] ids [0:2];
        lens = '{5, 6, 7, 20};
        ids  = '{64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000};
        cur_id = '0;
        repeat (3) @(negedge clk);
        chk(!rsp_req && !rx_clear && !dir_reader, "R1", {rsp_req, rx_clear, dir_reader}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!rsp_req && !rx_clear && !dir_reader, "R1", {rsp_req, rx_clear, dir_reader}, 0);
        for (int s = 0; s < 3; s++) begin
            load_id(ids[s]);
            for (int cm = 0; cm < 16; cm++)
                for (int li = 0; li < 4; li++)
                    for (int rq = 0; rq < 3; rq++)
                        run_frame(lens[li], cm, rq, 1'b1, 1'b0, '0);
        end
        // R6: bad CRC on frames that would otherwise be answered
        run_frame(6, 0, 0, 1'b0, 1'b0, '0);
        run_frame(6, 0, 1, 1'b0, 1'b0, '0);
        run_frame(16, 6, 0, 1'b0, 1'b0, '0);
        // R10: identifier swap while replying
        load_id(64'hA1B2_C3D4_E5F6_0718);
        run_frame(6, 0, 0, 1'b1, 1'b1, 64'h1122_3344_5566_7788);
        run_frame(6, 0, 1, 1'b1, 1'b0, '0);
        run_frame(16, 6, 0, 1'b1, 1'b1, 64'h0F0F_F0F0_0F0F_F0F0);
        run_frame(6, 0, 0, 1'b1, 1'b0, '0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule